// File: doc/BRIEF.md
# Bulk Erase Verify Sequencer

This block sits on the host side of a byte-wide flash device and carries out the complete chip-erase procedure through the device's command interface. After a start request, it writes the erase command twice. The first write arms the device and the second begins the erase. It then lets a programmable number of clocks pass and ends the erase by writing the verify command. That verify write also carries the address of the first byte to be checked.

Each byte is checked with the same two steps: a verify command write that latches the byte's address, then a read. The read must return all ones. If a byte comes back with any zero bit, the sequencer applies another erase pulse and checks that same byte again; it does not start over from the lowest address. A limit on the number of erase pulses stops a device that will not erase. In that case the sequencer reports failure and the address that would not clear. In both outcomes it leaves verify mode by writing the read command.

Every pin access passes through a bus-cycle generator. For a write, it holds chip enable and write enable low for a set number of clocks while the address and data are driven. For a read, it holds chip enable and output enable low for a set number of clocks and captures the data on the last of those clocks.

Top module: `bulk_erase_seq`

## Requirements
- R1: Each erase pulse is issued as two back-to-back command writes of value 20H. Any other command written while the first 20H is pending is a protocol error.
- R2: After the second 20H write, write enable stays high for at least ERASE_CLKS clocks. The next write must be the verify command A0H.
- R3: Every byte read is preceded by an A0H write to the address of that byte, and the read uses the same address. Verified addresses start at 0, and each A0H goes either to the same address as the previous one or to the next higher address.
- R4: A byte that reads anything other than FFH causes a new erase pulse (R1), after which verification resumes at that same address. The total number of A0H writes is therefore the array depth plus one for each re-check.
- R5: When every address up to the highest one has read FFH, the sequencer writes 00H, drops busy and raises done for exactly one clock.
- R6: At most MAX_PULSES erase pulses are issued per run. If a byte still fails on the last allowed pulse, the sequencer writes 00H and raises fail without pulsing done. fail_addr gives the failing byte. fail and fail_addr hold their values until the next accepted start, and that start clears fail.
- R7: In a write cycle, chip enable and write enable are low for exactly WR_CLKS clocks while the address is stable. Write enable is never low while output enable is low, and never low while chip enable is high.
- R8: In a read cycle, output enable is low for exactly RD_CLKS clocks, and the host does not drive the data bus during that time.
- R9: A start request is accepted only while busy is low. A start request while busy is high leaves the run and its outcome unchanged.
- R10: During and after reset, busy, done and fail are low, the bus is released (chip enable, write enable and output enable all high), and the host does not drive the data bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the erase procedure |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-clock pulse when a run succeeds |
| fail | output | 1 | High after a run hits the pulse limit |
| fail_addr | output | ADDR_W | Address of the byte that did not erase |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Host drives the data bus when high |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Two decisions can land on the same verify read: reaching the end of the array and running out of erase pulses. The bench sets up a flash model whose highest address only clears on exactly the last permitted pulse, and expects done with no fail. It then sets up a model where that address needs one pulse more, and expects fail with fail_addr at the top address. A second overlap is a start request that arrives while a run is in progress. The bench issues one mid-run and requires the pulse count, the verify-command count and the outcome to equal those of a run with no such request.

// File: rtl/bulk_erase_pkg.sv
package bulk_erase_pkg;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] BYTE_CLEAR = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_ERASE,
    S_WAIT,
    S_VCMD,
    S_VREAD,
    S_EXIT
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WLOW,
    PH_WHIGH,
    PH_RLOW
  } bus_phase_t;
endpackage

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int ERASE_CLKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic running
);
  localparam int CW = $clog2(ERASE_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(ERASE_CLKS);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign running = (cnt != '0);
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import bulk_erase_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int WR_CLKS = 2,
  parameter int RD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              ack,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int LONGEST = (WR_CLKS > RD_CLKS) ? WR_CLKS : RD_CLKS;
  localparam int CW      = $clog2(LONGEST + 1);

  bus_phase_t    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      ack       <= 1'b0;
      rd_data   <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
    end else begin
      ack <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req) begin
            fl_addr <= req_addr;
            fl_ce_n <= 1'b0;
            if (req_write) begin
              fl_dq_out <= req_data;
              fl_dq_oe  <= 1'b1;
              fl_we_n   <= 1'b0;
              cnt       <= CW'(WR_CLKS - 1);
              phase     <= PH_WLOW;
            end else begin
              fl_oe_n <= 1'b0;
              cnt     <= CW'(RD_CLKS - 1);
              phase   <= PH_RLOW;
            end
          end
        end
        PH_WLOW: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            phase   <= PH_WHIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WHIGH: begin
          fl_ce_n  <= 1'b1;
          fl_dq_oe <= 1'b0;
          ack      <= 1'b1;
          phase    <= PH_IDLE;
        end
        PH_RLOW: begin
          if (cnt == '0) begin
            rd_data <= fl_dq_in;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            ack     <= 1'b1;
            phase   <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import bulk_erase_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MAX_PULSES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  input  logic              tmr_running,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              tmr_load,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int                PW        = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  seq_state_t        state;
  logic              issued;
  logic              pass;
  logic [ADDR_W-1:0] addr;
  logic [PW-1:0]     pulses;

  always_comb begin
    bus_req   = !issued && (state != S_IDLE) && (state != S_WAIT);
    bus_write = (state != S_VREAD);
    bus_addr  = addr;
    unique case (state)
      S_SETUP, S_ERASE: bus_wdata = CMD_ERASE;
      S_VCMD:           bus_wdata = CMD_VERIFY;
      default:          bus_wdata = CMD_READ;
    endcase
  end

  assign tmr_load = (state == S_ERASE) && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      issued    <= 1'b0;
      pass      <= 1'b0;
      addr      <= '0;
      pulses    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req) issued <= 1'b1;
      if (bus_ack) issued <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            fail   <= 1'b0;
            addr   <= '0;
            pulses <= '0;
            state  <= S_SETUP;
          end
        end
        S_SETUP: if (bus_ack) state <= S_ERASE;
        S_ERASE: begin
          if (bus_ack) begin
            pulses <= pulses + 1'b1;
            state  <= S_WAIT;
          end
        end
        S_WAIT: if (!tmr_running) state <= S_VCMD;
        S_VCMD: if (bus_ack) state <= S_VREAD;
        S_VREAD: begin
          if (bus_ack) begin
            if (bus_rdata == BYTE_CLEAR) begin
              if (addr == LAST_ADDR) begin
                pass  <= 1'b1;
                state <= S_EXIT;
              end else begin
                addr  <= addr + 1'b1;
                state <= S_VCMD;
              end
            end else if (pulses == PW'(MAX_PULSES)) begin
              pass      <= 1'b0;
              fail_addr <= addr;
              state     <= S_EXIT;
            end else begin
              state <= S_SETUP;
            end
          end
        end
        S_EXIT: begin
          if (bus_ack) begin
            busy  <= 1'b0;
            done  <= pass;
            fail  <= !pass;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq #(
  parameter int ADDR_W     = 4,
  parameter int ERASE_CLKS = 12,
  parameter int WR_CLKS    = 2,
  parameter int RD_CLKS    = 2,
  parameter int MAX_PULSES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  logic              bus_req;
  logic              bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic              bus_ack;
  logic [7:0]        bus_rdata;
  logic              tmr_load;
  logic              tmr_running;

  erase_seq_ctrl #(
    .ADDR_W    (ADDR_W),
    .MAX_PULSES(MAX_PULSES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .tmr_running(tmr_running),
    .bus_req    (bus_req),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tmr_load   (tmr_load),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_addr  (fail_addr)
  );

  erase_timer #(
    .ERASE_CLKS(ERASE_CLKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .running(tmr_running)
  );

  flash_bus_cycle #(
    .ADDR_W (ADDR_W),
    .WR_CLKS(WR_CLKS),
    .RD_CLKS(RD_CLKS)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .req      (bus_req),
    .req_write(bus_write),
    .req_addr (bus_addr),
    .req_data (bus_wdata),
    .ack      (bus_ack),
    .rd_data  (bus_rdata),
    .fl_addr  (fl_addr),
    .fl_dq_out(fl_dq_out),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_in (fl_dq_in),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n)
  );
endmodule

// File: rtl/bulk_erase_seq_checker.sv
module bulk_erase_seq_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic fail,
  input logic fl_dq_oe,
  input logic fl_ce_n,
  input logic fl_we_n,
  input logic fl_oe_n
);
  assert_no_we_oe_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  assert_we_inside_ce_R7: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  assert_read_undriven_R8: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_fail_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  assert_fail_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (fail && !busy && !start) |=> fail);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind bulk_erase_seq bulk_erase_seq_checker u_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .fail    (fail),
  .fl_dq_oe(fl_dq_oe),
  .fl_ce_n (fl_ce_n),
  .fl_we_n (fl_we_n),
  .fl_oe_n (fl_oe_n)
);

// File: tb/bulk_erase_seq_test.sv
`timescale 1ns/1ps
module bulk_erase_seq_test;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int ERASE_CLKS = 12;
  localparam int WR_CLKS    = 2;
  localparam int RD_CLKS    = 2;
  localparam int MAX_PULSES = 5;
  localparam int NVEC       = 7;

  // columns: base need, slow address, slow need, expect success, expect fail address
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{1, 0,  1, 1, 0},
    '{1, 7,  3, 1, 0},
    '{2, 0,  4, 1, 0},
    '{1, 15, 5, 1, 0},
    '{1, 15, 6, 0, 15},
    '{1, 3,  7, 0, 3},
    '{5, 9,  5, 1, 0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy, done, fail;
  logic [ADDR_W-1:0] fail_addr;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_dq_out;
  logic              fl_dq_oe;
  logic [7:0]        fl_dq_in;
  logic              fl_ce_n, fl_we_n, fl_oe_n;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bulk_erase_seq #(
    .ADDR_W(ADDR_W), .ERASE_CLKS(ERASE_CLKS), .WR_CLKS(WR_CLKS),
    .RD_CLKS(RD_CLKS), .MAX_PULSES(MAX_PULSES)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  // flash model state
  int          need [DEPTH];
  int          m_pulses, m_a0, done_cnt, cyc_total;
  int          perr_r1, perr_r2, perr_r3, perr_r7, perr_r8;
  int          wlow, rlow, gap;
  bit          armed, gap_track, after_erase, prev_we, prev_oe;
  logic [7:0]        last_cmd;
  logic [ADDR_W-1:0] v_addr, fall_addr, rd_addr;

  assign fl_dq_in = (!fl_oe_n && !fl_ce_n && last_cmd == 8'hA0)
                    ? ((m_pulses >= need[v_addr]) ? 8'hFF : 8'h00) : 8'h5A;

  always @(negedge clk) begin
    cyc_total++;
    if (rst || (start && !busy)) begin
      m_pulses = 0; m_a0 = 0; done_cnt = 0;
      perr_r1 = 0; perr_r2 = 0; perr_r3 = 0; perr_r7 = 0; perr_r8 = 0;
      armed = 0; gap_track = 0; after_erase = 0; gap = 0;
      last_cmd = 8'h00; v_addr = '0;
      prev_we = 1; prev_oe = 1;
    end else begin
      if (done) done_cnt++;
      if (!fl_we_n && !fl_oe_n) perr_r7++;
      if (!fl_we_n && fl_ce_n) perr_r7++;
      if (!fl_oe_n && fl_dq_oe) perr_r8++;
      if (prev_we && !fl_we_n) begin
        fall_addr = fl_addr; wlow = 0;
        if (gap_track) begin
          if (gap < ERASE_CLKS) perr_r2++;
          gap_track = 0;
        end
      end
      if (!fl_we_n) wlow++;
      if (!prev_we && fl_we_n) begin
        if (wlow != WR_CLKS || fl_addr != fall_addr) perr_r7++;
        if (after_erase && fl_dq_out != 8'hA0) perr_r2++;
        after_erase = 0;
        if (fl_dq_out == 8'h20) begin
          if (armed) begin
            m_pulses++; armed = 0; gap_track = 1; gap = 0; after_erase = 1;
          end else armed = 1;
        end else begin
          if (armed) perr_r1++;
          armed = 0;
        end
        if (fl_dq_out == 8'hA0) begin
          if (m_a0 == 0 ? (fl_addr != '0)
                        : (fl_addr != v_addr && fl_addr != v_addr + 4'd1)) perr_r3++;
          v_addr = fl_addr; m_a0++;
        end
        last_cmd = fl_dq_out;
      end
      if (gap_track && fl_we_n) gap++;
      if (prev_oe && !fl_oe_n) rlow = 0;
      if (!fl_oe_n) begin rlow++; rd_addr = fl_addr; end
      if (!prev_oe && fl_oe_n) begin
        if (rlow != RD_CLKS) perr_r8++;
        if (last_cmd != 8'hA0 || rd_addr != v_addr) perr_r3++;
      end
      prev_we = fl_we_n; prev_oe = fl_oe_n;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // requirement-level model of the walk (R4, R6)
  function automatic void walk(output int p, output int a0, output int ok, output int fa);
    int a = 0;
    bit fin = 0;
    p = 1; a0 = 0; ok = 0; fa = 0;
    while (!fin) begin
      a0++;
      if (need[a] <= p) begin
        if (a == DEPTH - 1) begin ok = 1; fin = 1; end
        else a++;
      end else if (p == MAX_PULSES) begin
        fa = a; fin = 1;
      end else p++;
    end
  endfunction

  task automatic run_case(input int base, input int slow, input int n,
                          input int exp_ok, input int exp_fa, input bit poke);
    int ep, ea0, eok, efa, cyc;
    for (int i = 0; i < DEPTH; i++) need[i] = base;
    need[slow] = n;
    walk(ep, ea0, eok, efa);
    check("R4 model agrees with table", eok, exp_ok);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R9 start accepted when idle", busy, 1);
    check("R6 fail cleared by start", fail, 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R9 still busy after ignored start", busy, 1);
    end
    cyc = 0;
    while (busy && cyc < 20000) begin @(negedge clk); cyc++; end
    check("R5 run finished before timeout", int'(cyc < 20000), 1);
    repeat (2) @(negedge clk);
    check("R5 done pulse count", done_cnt, exp_ok);
    check("R6 fail flag", fail, 1 - exp_ok);
    if (exp_ok == 0) check("R6 fail address", int'(fail_addr), exp_fa);
    check("R1 erase pulses", m_pulses, ep);
    check("R4 verify command count", m_a0, ea0);
    check("R5 exit command", int'(last_cmd), 0);
    check("R1 erase pair protocol", perr_r1, 0);
    check("R2 erase wait and verify follow", perr_r2, 0);
    check("R3 verify address order", perr_r3, 0);
    check("R7 write cycle shape", perr_r7, 0);
    check("R8 read cycle shape", perr_r8, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 busy in reset", busy, 0);
    check("R10 ce_n in reset", fl_ce_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R10 done after reset", done, 0);
    check("R10 fail after reset", fail, 0);
    check("R10 bus released", int'({fl_we_n, fl_oe_n, fl_dq_oe}), 6);

    for (int v = 0; v < NVEC; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0);

    // fail must hold while idle (R6), then the next start clears it
    run_case(1, 6, 9, 0, 6, 1'b0);
    repeat (5) @(negedge clk);
    check("R6 fail held idle", fail, 1);
    check("R6 fail address held", int'(fail_addr), 6);

    // start while busy is ignored (R9)
    run_case(1, 10, 4, 1, 0, 1'b1);

    // reset in the middle of a run (R10)
    for (int i = 0; i < DEPTH; i++) need[i] = 3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R10 busy after mid-run reset", busy, 0);
    check("R10 pins after mid-run reset",
          int'({fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}), 14);
    repeat (3) @(negedge clk);
    check("R10 idle stays quiet", int'({busy, done, fail}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule